// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command bus from reset until the memory is ready for ordinary traffic. While the start-up pause runs, it drives the no-operation command and keeps clock enable and the data mask high, so the memory cannot drive the data bus. After the pause it closes every bank with a precharge-all command. It then programs the mode register with a value supplied on an input and issues a configurable number of auto refresh commands. Each command is followed by its own wait, counted in clock cycles.

A configuration input selects whether the refresh burst comes before or after the mode register write. When the last wait has elapsed, the block raises a ready flag. From that cycle on, the command, address, bank, clock-enable and mask pins follow the inputs from the normal memory controller. Before that cycle, those inputs have no effect on the pins.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: After reset is released, the command pins carry NOP (chip select, row strobe, column strobe, write enable = 0,1,1,1) with address and bank at zero. The first other command appears on sample PAUSE_CYC = CYC_PER_US*PAUSE_US. Sample n is the state after the n-th rising edge with reset high.
- R2: Clock enable and data mask stay high from reset until the ready flag is set, whatever the controller inputs carry.
- R3: The first command after the pause is precharge-all (0,0,1,0): address bit AP_BIT is 1, every other address bit is 0, and the bank is 0.
- R4: The command that follows the precharge appears exactly T_RP cycles after it.
- R5: Exactly REFRESH_CNT auto refresh commands (0,0,0,1) are issued. The next command, or the ready flag, follows each of them by exactly T_RC cycles.
- R6: The mode register write (0,0,0,0) carries modeValue on the address pins and bank 0. It is followed by NOP, and the next command or the ready flag comes exactly T_MRD cycles later.
- R7: With refreshFirst = 1, all refreshes come before the mode register write. With refreshFirst = 0, the mode register write comes first. The input must be stable from reset until the ready flag is set.
- R8: No activate command (0,0,1,1) appears on the pins before the mode register write.
- R9: Before the ready flag is set, the controller inputs have no effect on the pins. From the first cycle of the ready flag, every SDRAM pin equals its controller input in the same cycle.
- R10: The ready flag rises on the sample where the last command's wait ends, which is the last command's sample plus its wait. It then stays high until reset, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refreshFirst | input | 1 | 1: refresh burst before mode write; 0: after |
| modeValue | input | ADDR_W | Value written to the mode register |
| ctlCsN | input | 1 | Controller chip select |
| ctlRasN | input | 1 | Controller row strobe |
| ctlCasN | input | 1 | Controller column strobe |
| ctlWeN | input | 1 | Controller write enable |
| ctlAddr | input | ADDR_W | Controller address |
| ctlBa | input | BA_W | Controller bank |
| ctlCke | input | 1 | Controller clock enable |
| ctlDqm | input | 1 | Controller data mask |
| sdCsN | output | 1 | SDRAM chip select |
| sdRasN | output | 1 | SDRAM row strobe |
| sdCasN | output | 1 | SDRAM column strobe |
| sdWeN | output | 1 | SDRAM write enable |
| sdAddr | output | ADDR_W | SDRAM address |
| sdBa | output | BA_W | SDRAM bank |
| sdCke | output | 1 | SDRAM clock enable |
| sdDqm | output | 1 | SDRAM data mask |
| initDone | output | 1 | Ready flag; the bus now belongs to the controller |

## Verification
A wrong load value or a miscount in the shared wait counter moves a command by one or more cycles. The bench compares the sample index of every command with a schedule it computes itself, so such a shift shows at the next command and never later than the ready flag. A wrong refresh count, a wrong order or a wrong branch in the state machine changes the recorded command list, which is compared entry by entry in both orders. A mux select that flips too early lets the activate pattern or the low clock enable held on the controller inputs through to the pins during start-up, and this is caught on the first affected sample.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdCmd_e;

  typedef enum logic [1:0] {
    WAIT_RP  = 2'd0,
    WAIT_RC  = 2'd1,
    WAIT_MRD = 2'd2
  } waitSel_e;

  typedef struct packed {
    logic     issuePre;
    logic     issueRef;
    logic     issueMrs;
    logic     setDone;
    waitSel_e waitSel;
  } seqStrobe_t;

endpackage

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int CYC_PER_US  = 100,
  parameter int PAUSE_US    = 200,
  parameter int REFRESH_CNT = 8,
  parameter int T_RP        = 3,
  parameter int T_RC        = 9,
  parameter int T_MRD       = 2,
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int AP_BIT      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] modeValue,
  output logic              waitDone,
  output logic              refsDone,
  output logic [3:0]        seqCmd,
  output logic [ADDR_W-1:0] seqAddr,
  output logic [BA_W-1:0]   seqBa,
  output logic              seqDone
);

  localparam int PAUSE_CYC = CYC_PER_US * PAUSE_US;
  localparam int MAX_WAIT  = (PAUSE_CYC > T_RC) ? PAUSE_CYC : T_RC;
  localparam int CNT_W     = $clog2(MAX_WAIT + 1);
  localparam int REF_W     = $clog2(REFRESH_CNT + 1);
  localparam logic [CNT_W-1:0] PAUSE_LOAD = CNT_W'(PAUSE_CYC - 2);
  localparam logic [ADDR_W-1:0] AP_MASK   = ADDR_W'(1) << AP_BIT;

  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] waitLoad;
  logic [REF_W-1:0] refsLeft;
  logic             anyIssue;

  assign anyIssue = strobe.issuePre | strobe.issueRef | strobe.issueMrs;

  // wait length minus two: one cycle is the issue state, one the exit compare
  always_comb begin
    unique case (strobe.waitSel)
      WAIT_RP:  waitLoad = CNT_W'(T_RP - 2);
      WAIT_RC:  waitLoad = CNT_W'(T_RC - 2);
      default:  waitLoad = CNT_W'(T_MRD - 2);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= PAUSE_LOAD;
    end else if (anyIssue) begin
      waitCnt <= waitLoad;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign waitDone = (waitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refsLeft <= REF_W'(REFRESH_CNT);
    end else if (strobe.issueRef && refsLeft != '0) begin
      refsLeft <= refsLeft - 1'b1;
    end
  end

  assign refsDone = (refsLeft == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqCmd  <= CMD_NOP;
      seqAddr <= '0;
      seqBa   <= '0;
      seqDone <= 1'b0;
    end else begin
      seqCmd  <= CMD_NOP;
      seqAddr <= '0;
      seqBa   <= '0;
      if (strobe.issuePre) begin
        seqCmd  <= CMD_PRE;
        seqAddr <= AP_MASK;
      end else if (strobe.issueRef) begin
        seqCmd  <= CMD_REF;
      end else if (strobe.issueMrs) begin
        seqCmd  <= CMD_MRS;
        seqAddr <= modeValue;
      end
      if (strobe.setDone) begin
        seqDone <= 1'b1;
      end
    end
  end

  // checker state: observes the command register only
  logic             preSeen;
  logic             mrsSeen;
  logic [CNT_W-1:0] pauseWatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preSeen    <= 1'b0;
      mrsSeen    <= 1'b0;
      pauseWatch <= '0;
    end else begin
      if (seqCmd == CMD_PRE) preSeen <= 1'b1;
      if (seqCmd == CMD_MRS) mrsSeen <= 1'b1;
      if (pauseWatch != CNT_W'(PAUSE_CYC)) pauseWatch <= pauseWatch + 1'b1;
    end
  end

  // R1
  pause_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqCmd != CMD_NOP && !preSeen) |-> (pauseWatch == CNT_W'(PAUSE_CYC)));

  // R3
  first_is_pre_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqCmd != CMD_NOP && !preSeen) |-> (seqCmd == CMD_PRE && seqAddr == AP_MASK));

  // R6
  mrs_then_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqCmd == CMD_MRS) |=> (seqCmd == CMD_NOP));

  // R8
  no_early_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mrsSeen |-> (seqCmd != CMD_ACT));

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refreshFirst,
  input  logic       waitDone,
  input  logic       refsDone,
  output seqStrobe_t strobe
);

  typedef enum logic [3:0] {
    ST_PAUSE, ST_PRE, ST_WAIT_RP, ST_REF, ST_WAIT_RC,
    ST_MRS, ST_WAIT_MRD, ST_FINISH, ST_READY
  } seqState_e;

  seqState_e state, stateNext;
  logic      refFirstQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_PAUSE;
      refFirstQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_PRE) refFirstQ <= refreshFirst;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '{issuePre: 1'b0, issueRef: 1'b0, issueMrs: 1'b0,
                  setDone: 1'b0, waitSel: WAIT_RP};
    unique case (state)
      ST_PAUSE:    if (waitDone) stateNext = ST_PRE;
      ST_PRE: begin
        strobe.issuePre = 1'b1;
        strobe.waitSel  = WAIT_RP;
        stateNext       = ST_WAIT_RP;
      end
      ST_WAIT_RP:  if (waitDone) stateNext = refFirstQ ? ST_REF : ST_MRS;
      ST_REF: begin
        strobe.issueRef = 1'b1;
        strobe.waitSel  = WAIT_RC;
        stateNext       = ST_WAIT_RC;
      end
      ST_WAIT_RC: begin
        if (waitDone) begin
          if (!refsDone)      stateNext = ST_REF;
          else if (refFirstQ) stateNext = ST_MRS;
          else                stateNext = ST_FINISH;
        end
      end
      ST_MRS: begin
        strobe.issueMrs = 1'b1;
        strobe.waitSel  = WAIT_MRD;
        stateNext       = ST_WAIT_MRD;
      end
      ST_WAIT_MRD: if (waitDone) stateNext = refFirstQ ? ST_FINISH : ST_REF;
      ST_FINISH: begin
        strobe.setDone = 1'b1;
        stateNext      = ST_READY;
      end
      default:     stateNext = ST_READY;
    endcase
  end

  // R7
  mrs_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MRS) |-> (refFirstQ == refsDone));

  // R5
  ref_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REF) |-> !refsDone);

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int CYC_PER_US  = 100,
  parameter int PAUSE_US    = 200,
  parameter int REFRESH_CNT = 8,
  parameter int T_RP        = 3,
  parameter int T_RC        = 9,
  parameter int T_MRD       = 2,
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int AP_BIT      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refreshFirst,
  input  logic [ADDR_W-1:0] modeValue,
  input  logic              ctlCsN,
  input  logic              ctlRasN,
  input  logic              ctlCasN,
  input  logic              ctlWeN,
  input  logic [ADDR_W-1:0] ctlAddr,
  input  logic [BA_W-1:0]   ctlBa,
  input  logic              ctlCke,
  input  logic              ctlDqm,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [BA_W-1:0]   sdBa,
  output logic              sdCke,
  output logic              sdDqm,
  output logic              initDone
);

  seqStrobe_t        strobe;
  logic              waitDone;
  logic              refsDone;
  logic [3:0]        seqCmd;
  logic [ADDR_W-1:0] seqAddr;
  logic [BA_W-1:0]   seqBa;
  logic              seqDone;

  sdram_init_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .refreshFirst (refreshFirst),
    .waitDone     (waitDone),
    .refsDone     (refsDone),
    .strobe       (strobe)
  );

  sdram_init_dp #(
    .CYC_PER_US  (CYC_PER_US),
    .PAUSE_US    (PAUSE_US),
    .REFRESH_CNT (REFRESH_CNT),
    .T_RP        (T_RP),
    .T_RC        (T_RC),
    .T_MRD       (T_MRD),
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .AP_BIT      (AP_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .modeValue (modeValue),
    .waitDone  (waitDone),
    .refsDone  (refsDone),
    .seqCmd    (seqCmd),
    .seqAddr   (seqAddr),
    .seqBa     (seqBa),
    .seqDone   (seqDone)
  );

  assign initDone = seqDone;
  assign {sdCsN, sdRasN, sdCasN, sdWeN} =
    seqDone ? {ctlCsN, ctlRasN, ctlCasN, ctlWeN} : seqCmd;
  assign sdAddr = seqDone ? ctlAddr : seqAddr;
  assign sdBa   = seqDone ? ctlBa   : seqBa;
  assign sdCke  = seqDone ? ctlCke  : 1'b1;
  assign sdDqm  = seqDone ? ctlDqm  : 1'b1;

  // R2
  pins_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> (sdCke && sdDqm));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

endmodule

// File: tb/sdram_pwrup_seq_bench.sv
module sdram_pwrup_seq_bench;

  localparam int CPU  = 2;
  localparam int PUS  = 200;
  localparam int NREF = 8;
  localparam int TRP  = 3;
  localparam int TRC  = 5;
  localparam int TMRD = 2;
  localparam int AW   = 13;
  localparam int BW   = 2;
  localparam int PC   = CPU * PUS;
  localparam logic [AW-1:0] MODE_VAL = 13'h0032;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_MRS = 4'b0000, C_ACT = 4'b0011;

  // refresh-first schedule: {command, sample index}
  localparam int NTAB = NREF + 2;
  localparam logic [19:0] REF_FIRST_TAB [NTAB] = '{
    {C_PRE, 16'(PC)},
    {C_REF, 16'(PC + TRP + 0*TRC)},
    {C_REF, 16'(PC + TRP + 1*TRC)},
    {C_REF, 16'(PC + TRP + 2*TRC)},
    {C_REF, 16'(PC + TRP + 3*TRC)},
    {C_REF, 16'(PC + TRP + 4*TRC)},
    {C_REF, 16'(PC + TRP + 5*TRC)},
    {C_REF, 16'(PC + TRP + 6*TRC)},
    {C_REF, 16'(PC + TRP + 7*TRC)},
    {C_MRS, 16'(PC + TRP + 8*TRC)}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refreshFirst = 1'b1;
  logic [AW-1:0] modeValue = MODE_VAL;
  logic ctlCsN = 1'b0, ctlRasN = 1'b0, ctlCasN = 1'b1, ctlWeN = 1'b1;
  logic [AW-1:0] ctlAddr = 13'h1abc;
  logic [BW-1:0] ctlBa = 2'd3;
  logic ctlCke = 1'b0, ctlDqm = 1'b0;
  logic sdCsN, sdRasN, sdCasN, sdWeN, sdCke, sdDqm, initDone;
  logic [AW-1:0] sdAddr;
  logic [BW-1:0] sdBa;

  always #5 clk = ~clk;

  sdram_pwrup_seq #(
    .CYC_PER_US(CPU), .PAUSE_US(PUS), .REFRESH_CNT(NREF),
    .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .ADDR_W(AW), .BA_W(BW), .AP_BIT(10)
  ) u_sdram_pwrup_seq (
    .clk(clk), .rstN(rstN), .refreshFirst(refreshFirst), .modeValue(modeValue),
    .ctlCsN(ctlCsN), .ctlRasN(ctlRasN), .ctlCasN(ctlCasN), .ctlWeN(ctlWeN),
    .ctlAddr(ctlAddr), .ctlBa(ctlBa), .ctlCke(ctlCke), .ctlDqm(ctlDqm),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdAddr(sdAddr), .sdBa(sdBa), .sdCke(sdCke), .sdDqm(sdDqm),
    .initDone(initDone)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  int evCode [16];
  int evCyc  [16];
  int evAddr [16];
  int evBa   [16];
  int nEv;
  int doneCyc;
  int quietBad;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reset, release, record every non-NOP command until the ready flag
  task automatic runInit(input logic order);
    refreshFirst = order;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk({sdCsN, sdRasN, sdCasN, sdWeN} == C_NOP, "R1 reset cmd", {sdCsN, sdRasN, sdCasN, sdWeN}, C_NOP);
    chk(sdCke && sdDqm, "R2 reset cke/dqm", {sdCke, sdDqm}, 3);
    chk(!initDone, "R10 reset done", initDone, 0);
    rstN = 1'b1;
    nEv = 0; doneCyc = -1; quietBad = 0;
    for (int n = 1; n <= PC + 200; n++) begin
      @(negedge clk);
      if (initDone) begin
        doneCyc = n;
        break;
      end
      if (!(sdCke && sdDqm)) quietBad++;
      if ({sdCsN, sdRasN, sdCasN, sdWeN} != C_NOP && nEv < 16) begin
        evCode[nEv] = int'({sdCsN, sdRasN, sdCasN, sdWeN});
        evCyc[nEv]  = n;
        evAddr[nEv] = int'(sdAddr);
        evBa[nEv]   = int'(sdBa);
        nEv++;
      end else if ({sdCsN, sdRasN, sdCasN, sdWeN} == C_NOP && (sdAddr != '0 || sdBa != '0)) begin
        quietBad++;
      end
    end
  endtask

  initial begin
    int mrsIdx;
    int expCyc;
    int expCode;

    // run 1: refresh burst first, walk the table
    runInit(1'b1);
    chk(quietBad == 0, "R2 R9 pins quiet during init", quietBad, 0);
    chk(nEv == NTAB, "R5 R7 command count", nEv, NTAB);
    for (int i = 0; i < NTAB; i++) begin
      chk(evCode[i] == int'(REF_FIRST_TAB[i][19:16]), "R3 R5 R7 R8 command code", evCode[i], int'(REF_FIRST_TAB[i][19:16]));
      chk(evCyc[i] == int'(REF_FIRST_TAB[i][15:0]), "R1 R4 R5 command sample", evCyc[i], int'(REF_FIRST_TAB[i][15:0]));
    end
    chk(evAddr[0] == (1 << 10) && evBa[0] == 0, "R3 precharge address", evAddr[0], 1 << 10);
    chk(evAddr[NTAB-1] == int'(MODE_VAL) && evBa[NTAB-1] == 0, "R6 mode address", evAddr[NTAB-1], int'(MODE_VAL));
    chk(doneCyc == int'(REF_FIRST_TAB[NTAB-1][15:0]) + TMRD, "R6 R10 done sample", doneCyc, int'(REF_FIRST_TAB[NTAB-1][15:0]) + TMRD);

    // R9 handover: pins follow controller in the same cycle
    chk({sdCsN, sdRasN, sdCasN, sdWeN} == C_ACT && sdAddr == ctlAddr && sdBa == ctlBa,
        "R9 handover cmd", int'(sdAddr), int'(ctlAddr));
    chk(!sdCke && !sdDqm, "R9 handover cke/dqm", {sdCke, sdDqm}, 0);
    ctlCsN = 1'b1; ctlAddr = 13'h0155; ctlBa = 2'd1; ctlCke = 1'b1; ctlDqm = 1'b1;
    #1;
    chk(sdCsN && sdAddr == 13'h0155 && sdBa == 2'd1 && sdCke && sdDqm, "R9 handover follow", int'(sdAddr), 'h155);
    repeat (20) @(negedge clk);
    chk(initDone, "R10 done sticky", initDone, 1);
    ctlCsN = 1'b0; ctlAddr = 13'h1abc; ctlBa = 2'd3; ctlCke = 1'b0; ctlDqm = 1'b0;

    // run 2: mode write first, schedule computed here
    runInit(1'b0);
    chk(quietBad == 0, "R2 R9 pins quiet during init (mode first)", quietBad, 0);
    chk(nEv == NTAB, "R5 R7 command count (mode first)", nEv, NTAB);
    mrsIdx = 1;
    for (int i = 0; i < NTAB; i++) begin
      if (i == 0)           begin expCode = C_PRE; expCyc = PC; end
      else if (i == mrsIdx) begin expCode = C_MRS; expCyc = PC + TRP; end
      else                  begin expCode = C_REF; expCyc = PC + TRP + TMRD + (i - 2) * TRC; end
      chk(evCode[i] == expCode, "R7 R8 command code (mode first)", evCode[i], expCode);
      chk(evCyc[i] == expCyc, "R4 R5 R6 command sample (mode first)", evCyc[i], expCyc);
    end
    chk(evAddr[mrsIdx] == int'(MODE_VAL), "R6 mode address (mode first)", evAddr[mrsIdx], int'(MODE_VAL));
    chk(doneCyc == PC + TRP + TMRD + (NREF - 1) * TRC + TRC, "R5 R10 done sample (mode first)",
        doneCyc, PC + TRP + TMRD + NREF * TRC);

    // R10 reset clears the flag mid-operation and restarts the pause
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(!initDone && sdCke && sdDqm, "R10 reset clears done", initDone, 0);
    chk({sdCsN, sdRasN, sdCasN, sdWeN} == C_NOP, "R1 NOP after re-reset", {sdCsN, sdRasN, sdCasN, sdWeN}, C_NOP);
    rstN = 1'b1;
    repeat (PC - 1) @(negedge clk);
    chk({sdCsN, sdRasN, sdCasN, sdWeN} == C_NOP, "R1 still NOP before pause end", {sdCsN, sdRasN, sdCasN, sdWeN}, C_NOP);
    @(negedge clk);
    chk({sdCsN, sdRasN, sdCasN, sdWeN} == C_PRE, "R1 R3 precharge at pause end", {sdCsN, sdRasN, sdCasN, sdWeN}, C_PRE);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule